// File: doc/BRIEF.md
# Decimal-Exponent Rate Encoder and Queue Scheduling Word Packer

This block takes two plain integer rates (a floor rate and a ceiling rate) and turns each into a small base-10 floating-point code. The code is a 7-bit mantissa and a 4-bit decimal exponent. The rate is normalised by dividing it by ten, with truncation, once per clock cycle, until it fits in the mantissa. Both rates are normalised side by side.

When both rates have settled, the block packs the two codes into one 32-bit queue scheduling word. It adds a per-rate enable flag, a 4-bit weight and a scheduler-select flag, and it carries three reserved bits over from the previous register value. The finished word is presented with a one-cycle done strobe and is held until the next result.

The surrounding logic drives a one-cycle start together with the operands. The block latches the operands when it accepts the start, and it ignores any start that arrives while a conversion is still running.

Top module: `shaper_rate_packer`

## Requirements
- R1: Each rate is normalised as follows: while the value is above 127, it is divided by 10 (truncating) and its exponent is increased by one. The mantissa is the final value, which is at most 127. Only the low 4 bits of the exponent count are kept.
- R2: The ceiling-rate code sits in the packed word as follows: mantissa in bits 10:4, exponent in bits 3:0.
- R3: Bit 11 is 1 exactly when the latched ceiling rate is nonzero. A zero ceiling rate gives 0 in all of bits 11:0.
- R4: The floor-rate code sits as follows: mantissa in bits 26:20, exponent in bits 19:16. Bit 27 is 1 exactly when the floor rate is nonzero.
- R5: The weight input appears in bits 15:12, and the scheduler-select input appears in bit 31.
- R6: Bits 30:28 of the packed word equal bits 30:28 of the previous-value input that was latched at start. No other previous-value bit reaches the output.
- R7: Done is high for exactly one cycle. It rises 1 + S clock edges after the edge that accepts start, where S is the larger of the two division counts. The word output changes only together with done.
- R8: A start pulse that arrives while a conversion is running has no effect on the result or on its timing.
- R9: After reset, the packed word is 0 and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; operands are sampled with it |
| min_rate | input | 32 | Floor rate, plain integer |
| max_rate | input | 32 | Ceiling rate, plain integer |
| weight | input | 4 | Queue weight |
| sched_sel | input | 1 | Scheduler-select flag |
| prev_word | input | 32 | Previous register value, source of the reserved bits |
| word | output | 32 | Packed scheduling word |
| done | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach is a second start that lands while the conversion is busy. That window exists only while one of the rates is still being divided, and it is only a few cycles wide. The stimulus opens it by launching a conversion with the all-ones ceiling rate, which needs eight division steps. It then pulses start with completely different operands two cycles later. The bench checks that both the packed word and the completion time still match the first request. The wider sweep pairs every rate in a list of boundary values (0, 127, 128, 1279, 1280, 250000, 500000, all-ones and others) as floor and as ceiling. This exercises every combination of step counts, including pairs where either rate is the slower one.

// File: rtl/shaper_rate_packer.sv
module shaper_rate_packer #(
  parameter int RATE_W = 32,
  parameter int MANT_W = 7,
  parameter int EXP_W  = 4,
  parameter int WGT_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] min_rate,
  input  logic [RATE_W-1:0] max_rate,
  input  logic [WGT_W-1:0]  weight,
  input  logic              sched_sel,
  input  logic [WORD_W-1:0] prev_word,
  output logic [WORD_W-1:0] word,
  output logic              done
);
  localparam int HI_E  = 0;
  localparam int HI_M  = HI_E + EXP_W;
  localparam int HI_EN = HI_M + MANT_W;
  localparam int WT    = HI_EN + 1;
  localparam int LO_E  = WT + WGT_W;
  localparam int LO_M  = LO_E + EXP_W;
  localparam int LO_EN = LO_M + MANT_W;
  localparam int RSV   = LO_EN + 1;
  localparam int SEL   = WORD_W - 1;
  localparam int RSV_W = SEL - RSV;
  localparam logic [RATE_W-1:0] LIMIT = RATE_W'((1 << MANT_W) - 1);
  localparam logic [RATE_W-1:0] TEN   = RATE_W'(10);

  logic              busy;
  logic [RATE_W-1:0] lo_v, hi_v;
  logic [EXP_W-1:0]  lo_x, hi_x;
  logic              lo_nz, hi_nz, sel_q;
  logic [WGT_W-1:0]  wgt_q;
  logic [RSV_W-1:0]  rsv_q;
  logic              lo_big, hi_big, settle;
  logic [WORD_W-1:0] packed_w;

  assign lo_big = lo_v > LIMIT;
  assign hi_big = hi_v > LIMIT;
  assign settle = busy && !lo_big && !hi_big;

  always_comb begin
    packed_w              = '0;
    packed_w[HI_M-1:HI_E] = hi_x;
    packed_w[HI_EN-1:HI_M] = hi_v[MANT_W-1:0];
    packed_w[HI_EN]       = hi_nz;
    packed_w[LO_E-1:WT]   = wgt_q;
    packed_w[LO_M-1:LO_E] = lo_x;
    packed_w[LO_EN-1:LO_M] = lo_v[MANT_W-1:0];
    packed_w[LO_EN]       = lo_nz;
    packed_w[SEL-1:RSV]   = rsv_q;
    packed_w[SEL]         = sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      lo_v  <= '0;
      hi_v  <= '0;
      lo_x  <= '0;
      hi_x  <= '0;
      lo_nz <= 1'b0;
      hi_nz <= 1'b0;
      sel_q <= 1'b0;
      wgt_q <= '0;
      rsv_q <= '0;
      word  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          lo_v  <= min_rate;
          hi_v  <= max_rate;
          lo_x  <= '0;
          hi_x  <= '0;
          lo_nz <= |min_rate;
          hi_nz <= |max_rate;
          sel_q <= sched_sel;
          wgt_q <= weight;
          rsv_q <= prev_word[SEL-1:RSV];
        end
      end else if (settle) begin
        busy <= 1'b0;
        word <= packed_w;
        done <= 1'b1;
      end else begin
        if (lo_big) begin
          lo_v <= lo_v / TEN;
          lo_x <= lo_x + 1'b1;
        end
        if (hi_big) begin
          hi_v <= hi_v / TEN;
          hi_x <= hi_x + 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_WORD_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(word)); // R7
  AST_LO_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !settle && lo_big) |=> (lo_v < $past(lo_v))); // R1
  AST_HI_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !settle && hi_big) |=> (hi_v < $past(hi_v))); // R1
  AST_HI_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word[HI_EN] == (word[HI_EN-1:HI_M] != '0))); // R3
  AST_LO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word[LO_EN] == (word[LO_EN-1:LO_M] != '0))); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(wgt_q) && $stable(rsv_q) && $stable(sel_q))); // R8
endmodule

// File: tb/test_shaper_rate_packer.sv
module test_shaper_rate_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] min_rate = '0, max_rate = '0, prev_word = '0;
  logic [3:0]  weight = '0;
  logic        sched_sel = 1'b0;
  logic [31:0] word;
  logic        done;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  shaper_rate_packer i_shaper_rate_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .min_rate(min_rate),
    .max_rate(max_rate), .weight(weight), .sched_sel(sched_sel),
    .prev_word(prev_word), .word(word), .done(done));

  function automatic logic [11:0] enc(input logic [31:0] r, output int steps);
    logic [31:0] v = r;
    int e = 0;
    while (v > 127) begin
      v = v / 10;
      e++;
    end
    steps = e;
    return {(r != 0), v[6:0], 4'(e)};
  endfunction

  function automatic logic [31:0] expect_word(input logic [31:0] mn, mx, pv,
      input logic [3:0] w, input logic s, output int lat);
    int smn, smx;
    logic [11:0] a, b;
    a = enc(mn, smn);
    b = enc(mx, smx);
    lat = 1 + ((smn > smx) ? smn : smx);
    return {s, pv[30:28], a, w, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] mn, mx, pv, input logic [3:0] w,
      input logic s, input bit intrude);
    int lat, cnt;
    logic [31:0] exp;
    exp = expect_word(mn, mx, pv, w, s, lat);
    @(negedge clk);
    min_rate = mn; max_rate = mx; prev_word = pv; weight = w; sched_sel = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 60) begin
      if (intrude && cnt == 2) begin
        min_rate = 32'd5; max_rate = 32'd7; prev_word = ~pv;
        weight = ~w; sched_sel = ~s; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(intrude ? "R8 word" : "R1/R2/R3/R4/R5/R6 word", word, exp);
    check(intrude ? "R8 latency" : "R7 latency", 32'(cnt), 32'(lat));
    @(negedge clk);
    check("R7 done width", {31'b0, done}, 32'd0);
    check("R7 word hold", word, exp);
  endtask

  initial begin
    logic [31:0] rates [12];
    rates = '{32'd0, 32'd1, 32'd127, 32'd128, 32'd129, 32'd1279, 32'd1280,
              32'd99999, 32'd250000, 32'd500000, 32'h8000_0000, 32'hFFFF_FFFF};
    #25;
    check("R9 word reset", word, 32'd0);
    check("R9 done reset", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        run(rates[i], rates[j], 32'(i * 12 + j) * 32'h9E37_79B9,
            4'(i + 3 * j), 1'((i + j) & 1), 1'b0);
    run(32'd250000, 32'hFFFF_FFFF, 32'h5000_0000, 4'hA, 1'b1, 1'b1);
    run(32'd0, 32'hFFFF_FFFF, 32'h8FFF_FFFF, 4'h3, 1'b0, 1'b1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule